// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor that uses overlapping register windows. Every instruction addresses 32 architectural registers with 5-bit numbers. Eight of them are globals that never move. The other 24 come from a circular bank of physical registers, and a current window pointer selects which part of that bank they map to. The bank holds 16 entries per window plus the 8 globals. Each window owns 8 local registers and 8 incoming registers. Its outgoing registers are the incoming registers of the next window down. Because of this overlap, a caller can hand arguments to a callee, and get results back, without any copying.

The block has two combinational read ports and one write port that takes effect at the clock edge. A save request, issued on a call, moves the window down by one. A restore request, issued on a return, moves it back up. The block keeps a count of saved windows. It raises an overflow flag when a save would reuse a window that is still occupied, and an underflow flag when a restore finds no saved window. In either case the move is refused. Spilling to memory, filling from memory and trap handling are left to the surrounding logic.

Top module: `wreg_file`

## Requirements
- R1: Architectural numbers map by range as follows: 0–7 are globals, 8–15 are outgoing, 16–23 are local and 24–31 are incoming. Globals read the same value in every window.
- R2: Register 0 always reads as zero, and a write to register 0 has no effect.
- R3: Reads are combinational. A write lands at the rising clock edge. A read of the register being written in that same cycle returns the old value.
- R4: After reset the window pointer is 0, the saved-window count is 0, both flags are low and every register reads zero.
- R5: A save alone, when accepted, moves the pointer to (pointer − 1) mod NWIN. A value written to outgoing register 8+k before the save reads back as incoming register 24+k afterwards.
- R6: A restore alone, when accepted, moves the pointer to (pointer + 1) mod NWIN. The caller's locals are seen again unchanged, and values the callee wrote to its incoming registers show up in the caller's outgoing registers.
- R7: If a save arrives while NWIN−1 windows are already saved, overflow is high in that cycle and the pointer and count stay unchanged.
- R8: If a restore arrives while no window is saved, underflow is high in that cycle and the pointer stays unchanged.
- R9: If save and restore are both high in the same cycle, the window does not move and neither flag is raised.
- R10: A write in the same cycle as a save or restore is decoded against the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_addr | input | 5 | Read port A architectural number |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 5 | Read port B architectural number |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural number |
| wr_data | input | DW | Write data |
| save | input | 1 | Move window for a call |
| restore | input | 1 | Move window for a return |
| cwp | output | $clog2(NWIN) | Current window pointer |
| overflow | output | 1 | Save refused: no free window |
| underflow | output | 1 | Restore refused: no saved window |

## Verification
A write and a window move can happen in the same cycle. In that case the write has to be decoded with the window that was current before the move. The bench forces this collision in directed steps, where the outgoing, local and incoming registers are written in the very cycle a save or restore is issued. Each value is then read back through the new window's architectural numbers. The bench also makes the collision happen often under random stimulus. A frame-based reference model keeps the write in the pre-move frame and updates the depth afterwards, and it judges every read and flag.

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              ra_addr,
  output logic [DW-1:0]           ra_data,
  input  logic [4:0]              rb_addr,
  output logic [DW-1:0]           rb_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    save,
  input  logic                    restore,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic                    overflow,
  output logic                    underflow
);
  localparam int CW = $clog2(NWIN);
  localparam int PR = 8 + 16 * NWIN;
  localparam int PW = $clog2(PR);
  localparam logic [CW-1:0] LASTW = CW'(NWIN - 1);

  logic [DW-1:0] rf [PR];
  logic [CW-1:0] cwp_q, occ_q;

  wire [CW-1:0] cwp_dn = (cwp_q == '0) ? LASTW : cwp_q - 1'b1;
  wire [CW-1:0] cwp_up = (cwp_q == LASTW) ? '0 : cwp_q + 1'b1;

  function automatic logic [PW-1:0] phys(input logic [4:0] a,
                                         input logic [CW-1:0] cur,
                                         input logic [CW-1:0] prev);
    int idx;
    case (a[4:3])
      2'd0:    idx = int'(a);
      2'd1:    idx = 16 + 16 * int'(prev) + int'(a[2:0]);
      2'd2:    idx = 8 + 16 * int'(cur) + int'(a[2:0]);
      default: idx = 16 + 16 * int'(cur) + int'(a[2:0]);
    endcase
    return PW'(idx);
  endfunction

  assign ra_data = (ra_addr == 5'd0) ? '0 : rf[phys(ra_addr, cwp_q, cwp_dn)];
  assign rb_data = (rb_addr == 5'd0) ? '0 : rf[phys(rb_addr, cwp_q, cwp_dn)];

  wire do_save = save & ~restore;
  wire do_rest = restore & ~save;
  assign overflow  = do_save & (occ_q == LASTW);
  assign underflow = do_rest & (occ_q == '0);
  assign cwp = cwp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PR; i++) rf[i] <= '0;
    end else if (wr_en && wr_addr != 5'd0) begin
      rf[phys(wr_addr, cwp_q, cwp_dn)] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q <= '0;
      occ_q <= '0;
    end else if (do_save && !overflow) begin
      cwp_q <= cwp_dn;
      occ_q <= occ_q + 1'b1;
    end else if (do_rest && !underflow) begin
      cwp_q <= cwp_up;
      occ_q <= occ_q - 1'b1;
    end
  end

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));
  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (save && restore) |=> (cwp == $past(cwp)));
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (cwp == $past(cwp)));
  p_unf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cwp == $past(cwp)));
  p_save_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (save && !restore && !overflow) |=> (cwp != $past(cwp) || NWIN == 1));
  p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == 5'd0) |-> (ra_data == '0));
endmodule

// File: tb/wreg_file_bench.sv
`timescale 1ns/1ps
module wreg_file_bench;
  localparam int NW = 8;
  localparam int DW = 32;
  localparam int CW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_en = 1'b0, save = 1'b0, restore = 1'b0;
  logic [DW-1:0] ra_data, rb_data;
  logic [CW-1:0] cwp;
  logic overflow, underflow;

  always #2.5 clk = ~clk;

  wreg_file #(.NWIN(NW), .DW(DW)) u_wreg_file (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save(save), .restore(restore),
    .cwp(cwp), .overflow(overflow), .underflow(underflow));

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] gm [8];
  logic [DW-1:0] lm [NW][8];
  logic [DW-1:0] im [NW][8];
  int dep = 0;

  function automatic logic [DW-1:0] mread(input logic [4:0] a);
    if (a == 0) return '0;
    case (a[4:3])
      2'd0: return gm[a[2:0]];
      2'd1: return im[(dep + 1) % NW][a[2:0]];
      2'd2: return lm[dep][a[2:0]];
      default: return im[dep][a[2:0]];
    endcase
  endfunction

  function automatic logic [CW-1:0] mcwp();
    return CW'((NW - dep) % NW);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) gm[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin lm[w][i] = '0; im[w][i] = '0; end
    dep = 0;
  endtask

  // one cycle: drive at negedge, check before edge, update model after edge
  task automatic step(input string req, input logic [4:0] a, input logic [4:0] b,
                      input logic we, input logic [4:0] wa, input logic [DW-1:0] wd,
                      input logic sv, input logic rs);
    bit eo, eu;
    @(negedge clk);
    ra_addr = a; rb_addr = b; wr_en = we; wr_addr = wa; wr_data = wd;
    save = sv; restore = rs;
    #1;
    eo = sv && !rs && (dep == NW - 1);
    eu = rs && !sv && (dep == 0);
    chk({req, " rdA"}, ra_data, mread(a));
    chk({req, " rdB"}, rb_data, mread(b));
    chk({req, " cwp"}, DW'(cwp), DW'(mcwp()));
    chk({req, " ovf"}, DW'(overflow), DW'(eo));
    chk({req, " unf"}, DW'(underflow), DW'(eu));
    @(posedge clk);
    if (we && wa != 0) begin
      case (wa[4:3])
        2'd0: gm[wa[2:0]] = wd;
        2'd1: im[(dep + 1) % NW][wa[2:0]] = wd;
        2'd2: lm[dep][wa[2:0]] = wd;
        default: im[dep][wa[2:0]] = wd;
      endcase
    end
    if (sv && !rs && !eo) dep++;
    else if (rs && !sv && !eu) dep--;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R4 reset state
    for (int a = 0; a < 32; a += 3) step("R4", 5'(a), 5'(31 - a), 0, 0, 0, 0, 0);

    // R2 write to r0 ignored
    step("R2", 0, 0, 1, 5'd0, 32'hdead_beef, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0);

    // R3 same-cycle read returns old value, R1 globals
    step("R3", 5'd3, 5'd3, 1, 5'd3, 32'h1111_0003, 0, 0);
    step("R3", 5'd3, 5'd17, 1, 5'd17, 32'h2222_0001, 0, 0);
    step("R1", 5'd17, 5'd3, 1, 5'd9, 32'h3333_0001, 0, 0);

    // R5 out->in across save; R10 write in save cycle uses old window
    step("R10", 5'd9, 5'd17, 1, 5'd10, 32'h4444_0002, 1, 0);
    step("R5", 5'd25, 5'd26, 0, 0, 0, 0, 0);
    step("R1", 5'd3, 5'd17, 1, 5'd24, 32'h5555_0000, 0, 0);

    // R6 restore: callee in -> caller out, locals intact; R10 with restore
    step("R10", 5'd24, 5'd3, 1, 5'd27, 32'h6666_0003, 0, 1);
    step("R6", 5'd8, 5'd11, 0, 0, 0, 0, 0);
    step("R6", 5'd17, 5'd9, 0, 0, 0, 0, 0);

    // R8 underflow at depth 0
    step("R8", 5'd17, 5'd3, 0, 0, 0, 0, 1);
    step("R8", 5'd17, 5'd3, 0, 0, 0, 0, 0);

    // R9 both requests
    step("R9", 5'd17, 5'd8, 0, 0, 0, 1, 1);
    step("R9", 5'd17, 5'd8, 0, 0, 0, 0, 0);

    // R7 overflow after NW-1 saves, with locals tagged per depth
    for (int k = 0; k < NW - 1; k++)
      step("R7", 5'd16, 5'd8, 1, 5'd16, 32'h7700_0000 | k, 1, 0);
    step("R7", 5'd16, 5'd8, 1, 5'd16, 32'h77ff_0000, 1, 0);
    step("R7", 5'd16, 5'd24, 0, 0, 0, 0, 0);
    for (int k = 0; k < NW - 1; k++) step("R6", 5'd16, 5'd24, 0, 0, 0, 0, 1);
    step("R6", 5'd16, 5'd8, 0, 0, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] a, b, wa;
      logic we, sv, rs;
      int r;
      a = 5'($urandom_range(0, 31));
      b = 5'($urandom_range(0, 31));
      wa = 5'($urandom_range(0, 31));
      we = ($urandom_range(0, 3) != 0);
      r = $urandom_range(0, 9);
      sv = (r < 3) || (r == 9);
      rs = (r >= 5);
      step("R1", a, b, we, wa, $urandom(), sv, rs);
    end

    finish_run();
  end
endmodule